// File: doc/BRIEF.md
# Double-Buffered Disk-to-Memory DMA Engine

This block sits between a floppy disk controller and a 16-bit system memory. The disk controller pulses a data-request strobe with a byte. If the transfer counter is nonzero and the request source is set to the disk controller, the block counts the request. In the read direction it also stores the byte in one of two 16-byte holding buffers, filled in turn. When a buffer becomes full, the block raises a bus request and carries on filling the other buffer.

When the bus arbiter grants the bus, the block drops its request and writes the buffered bytes to memory as big-endian 16-bit words, one word per clock, at an address that advances by two. It writes the older buffer first. If the buffer being filled is also full, it writes that buffer next. A one-cycle done pulse ends the burst and reports how many words moved, so the arbiter can take the bus back. If both buffers are full when another one completes, a sticky error flag is set. The disk controller's interrupt line is passed through, together with a strobe on each change.

Top module: `fdma_ctrl`

## Requirements
- R1: After reset, bus request, memory write strobe, done pulse, error flag and interrupt output are low, and the counter readback and memory address are zero.
- R2: A data request is accepted only when the counter is nonzero and control bit 1 (request source) is 1. Each accepted request decrements the counter by one. Any other request leaves the counter unchanged.
- R3: When control bit 0 (direction) is 0, accepted bytes are stored in arrival order. When it is 1, accepted requests store nothing and raise no bus request, although the counter still decrements.
- R4: The 16th byte stored in a buffer marks that buffer full and raises bus request. If the other buffer is empty, filling continues in it from position zero.
- R5: When a buffer fills while the other is still full, the error flag is set and no switch takes place. Further bytes are dropped until a burst empties the buffer. The error stays set until the control register is written.
- R6: In the cycle after the rising edge of bus grant, bus request is low, unless a buffer filled in that same cycle.
- R7: On a grant, the older buffer is written first if it is full. It is written as 8 words, each with the even-indexed byte in bits 15:8 and the odd-indexed byte in bits 7:0.
- R8: After the older buffer, the buffer being filled is written too if it is full, and its fill position returns to zero. The done pulse reports 0, 8 or 16 words. If the older buffer is not full, the burst moves 0 words.
- R9: The memory address is loadable and advances by 2 after each word written. The counter is loadable and reads back its current value.
- R10: During a burst, one word is written on every clock. The done pulse comes in the cycle after the last write, with the write strobe low.
- R11: The interrupt output follows the disk controller interrupt one cycle later, and a one-cycle change strobe comes with each change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we_i | input | 1 | Control register write; also clears the error flag |
| cfg_wdata_i | input | 2 | Control value: bit 1 request source, bit 0 direction |
| cnt_we_i | input | 1 | Counter load strobe |
| cnt_wdata_i | input | CNT_W | Counter load value |
| cnt_o | output | CNT_W | Counter readback |
| addr_we_i | input | 1 | Memory address load strobe |
| addr_wdata_i | input | ADDR_W | Memory address load value |
| req_i | input | 1 | Disk data-request strobe |
| req_byte_i | input | 8 | Disk data byte |
| fdc_irq_i | input | 1 | Disk controller interrupt request |
| irq_o | output | 1 | Interrupt pass-through |
| irq_chg_o | output | 1 | Interrupt change strobe |
| bus_req_o | output | 1 | Bus request |
| bus_gnt_i | input | 1 | Bus grant, held for the burst |
| mem_we_o | output | 1 | Memory word write strobe |
| mem_addr_o | output | ADDR_W | Memory byte address (also address readback) |
| mem_data_o | output | 16 | Memory write data |
| burst_done_o | output | 1 | End-of-burst pulse |
| burst_words_o | output | WCNT_W | Words moved by the last burst |
| err_o | output | 1 | Sticky overrun error |

## Verification
Bursts are run after one full buffer, after two full buffers, and with nothing full. These three runs tell the 8-, 16- and 0-word paths apart and show the oldest-first ordering. Random byte values expose any swap of the high and low byte within a word. An overrun run separates the error and drop behaviour from normal switching. Runs with the counter at zero, the source bit cleared and the direction bit set each separate one gating condition on whether a request counts and whether its byte is stored. Randomly sized fill bursts, each followed by a grant, are compared word by word with a bench model of the buffer state.

// File: rtl/fdma_pkg.sv
// Shared definitions for the disk DMA engine.
package fdma_pkg;
    // Burst sequencer states.
    typedef enum logic {
        DR_IDLE  = 1'b0,
        DR_BURST = 1'b1
    } drain_st_t;

    localparam int WORD_W = 16;
endpackage

// File: rtl/fdma_pingpong.sv
// Two alternating byte buffers with per-buffer full flags.
// Assumes: BUF_BYTES is an even power of two; pos_clr and writes do not coincide.
module fdma_pingpong #(
    parameter int BUF_BYTES = 16,
    parameter int IDX_W     = $clog2(BUF_BYTES / 2)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [7:0]  wr_byte,
    input  logic [1:0]  clr_full,
    input  logic        pos_clr,
    input  logic        rd_sel,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [1:0]  full,
    output logic        act,
    output logic        fill_evt,
    output logic        ovf_evt,
    output logic [15:0] rd_word
);
    localparam int POS_W = $clog2(BUF_BYTES) + 1;

    logic [7:0]       store_q [2][BUF_BYTES];
    logic [POS_W-1:0] pos_q;
    logic             act_q;
    logic [1:0]       full_q;
    logic             room;

    assign room     = pos_q < POS_W'(BUF_BYTES);
    assign fill_evt = wr_en && (pos_q == POS_W'(BUF_BYTES - 1));
    assign ovf_evt  = fill_evt && full_q[~act_q];
    assign full     = full_q;
    assign act      = act_q;
    assign rd_word  = {store_q[rd_sel][{rd_idx, 1'b0}], store_q[rd_sel][{rd_idx, 1'b1}]};

    // Capture an accepted byte at the current fill position.
    always_ff @(posedge clk) begin
        if (wr_en && room) begin
            store_q[act_q][pos_q[POS_W-2:0]] <= wr_byte;
        end
    end

    // Track fill position, active buffer and full flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q  <= '0;
            act_q  <= 1'b0;
            full_q <= 2'b00;
        end else begin
            if (pos_clr) begin
                pos_q <= '0;
            end else if (wr_en && room) begin
                if (fill_evt && !full_q[~act_q]) begin
                    act_q <= ~act_q;
                    pos_q <= '0;
                end else begin
                    pos_q <= pos_q + POS_W'(1);
                end
            end
            for (int b = 0; b < 2; b++) begin
                full_q[b] <= (full_q[b] && !clr_full[b]) || (fill_evt && (act_q == 1'(b)));
            end
        end
    end
endmodule

// File: rtl/fdma_drain.sv
// Burst sequencer: writes full buffers to memory as big-endian words.
// Assumes: the grant stays high until the done pulse; no address load mid-burst.
module fdma_drain
    import fdma_pkg::*;
#(
    parameter int BUF_BYTES = 16,
    parameter int ADDR_W    = 24,
    parameter int IDX_W     = $clog2(BUF_BYTES / 2),
    parameter int WCNT_W    = $clog2(BUF_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        full,
    input  logic              act,
    input  logic              addr_we,
    input  logic [ADDR_W-1:0] addr_wdata,
    input  logic [15:0]       rd_word,
    output logic [1:0]        clr_full,
    output logic              pos_clr,
    output logic              rd_sel,
    output logic [IDX_W-1:0]  rd_idx,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_data,
    output logic              done,
    output logic [WCNT_W-1:0] words
);
    localparam int WORDS = BUF_BYTES / 2;

    drain_st_t         st_q;
    logic              sel_q;
    logic              second_q;
    logic [IDX_W-1:0]  idx_q;
    logic [WCNT_W-1:0] cnt_q;
    logic [ADDR_W-1:0] addr_q;
    logic              last;
    logic              more;

    assign last     = (st_q == DR_BURST) && (idx_q == IDX_W'(WORDS - 1));
    assign more     = !second_q && full[act];
    assign clr_full = last ? (2'b01 << sel_q) : 2'b00;
    assign pos_clr  = last && second_q;
    assign rd_sel   = sel_q;
    assign rd_idx   = idx_q;
    assign mem_we   = (st_q == DR_BURST);
    assign mem_addr = addr_q;
    assign mem_data = rd_word;

    // Memory address: software load, else step by one word per write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (addr_we) begin
            addr_q <= addr_wdata;
        end else if (st_q == DR_BURST) begin
            addr_q <= addr_q + ADDR_W'(2);
        end
    end

    // Burst sequencing: older buffer first, then the active one if full.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= DR_IDLE;
            sel_q    <= 1'b0;
            second_q <= 1'b0;
            idx_q    <= '0;
            cnt_q    <= '0;
            done     <= 1'b0;
            words    <= '0;
        end else begin
            done <= 1'b0;
            case (st_q)
                DR_IDLE: begin
                    if (start) begin
                        if (full[~act]) begin
                            st_q     <= DR_BURST;
                            sel_q    <= ~act;
                            second_q <= 1'b0;
                            idx_q    <= '0;
                            cnt_q    <= '0;
                        end else begin
                            done  <= 1'b1;
                            words <= '0;
                        end
                    end
                end
                DR_BURST: begin
                    idx_q <= idx_q + IDX_W'(1);
                    cnt_q <= cnt_q + WCNT_W'(1);
                    if (last) begin
                        if (more) begin
                            sel_q    <= act;
                            second_q <= 1'b1;
                            idx_q    <= '0;
                        end else begin
                            st_q  <= DR_IDLE;
                            done  <= 1'b1;
                            words <= cnt_q + WCNT_W'(1);
                        end
                    end
                end
                default: st_q <= DR_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/fdma_ctrl.sv
// Top of the disk DMA engine: control, counter, bus request, interrupt pass-through.
// Assumes: inputs are synchronous to clk; the arbiter holds the grant until the done pulse.
module fdma_ctrl #(
    parameter int BUF_BYTES = 16,
    parameter int ADDR_W    = 24,
    parameter int CNT_W     = 16,
    parameter int WCNT_W    = $clog2(BUF_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we_i,
    input  logic [1:0]        cfg_wdata_i,
    input  logic              cnt_we_i,
    input  logic [CNT_W-1:0]  cnt_wdata_i,
    output logic [CNT_W-1:0]  cnt_o,
    input  logic              addr_we_i,
    input  logic [ADDR_W-1:0] addr_wdata_i,
    input  logic              req_i,
    input  logic [7:0]        req_byte_i,
    input  logic              fdc_irq_i,
    output logic              irq_o,
    output logic              irq_chg_o,
    output logic              bus_req_o,
    input  logic              bus_gnt_i,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [15:0]       mem_data_o,
    output logic              burst_done_o,
    output logic [WCNT_W-1:0] burst_words_o,
    output logic              err_o
);
    localparam int IDX_W = $clog2(BUF_BYTES / 2);

    logic [1:0]       ctl_q;
    logic [CNT_W-1:0] cnt_q;
    logic             err_q, breq_q, gnt_q, irq_q, chg_q;
    logic             accept, wr_en, start;
    logic [1:0]       full, clr_full;
    logic             act, fill_evt, ovf_evt, pos_clr, rd_sel;
    logic [IDX_W-1:0] rd_idx;
    logic [15:0]      rd_word;

    assign accept = req_i && (cnt_q != '0) && ctl_q[1];
    assign wr_en  = accept && !ctl_q[0];
    assign start  = bus_gnt_i && !gnt_q;

    assign cnt_o     = cnt_q;
    assign err_o     = err_q;
    assign bus_req_o = breq_q;
    assign irq_o     = irq_q;
    assign irq_chg_o = chg_q;

    // Control register, counter and sticky error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= 2'b00;
            cnt_q <= '0;
            err_q <= 1'b0;
        end else begin
            if (cfg_we_i) begin
                ctl_q <= cfg_wdata_i;
                err_q <= 1'b0;
            end
            if (ovf_evt) err_q <= 1'b1;
            if (cnt_we_i) cnt_q <= cnt_wdata_i;
            else if (accept) cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    // Bus request: raised on a buffer fill, dropped by a new grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            breq_q <= 1'b0;
            gnt_q  <= 1'b0;
        end else begin
            gnt_q <= bus_gnt_i;
            if (start) breq_q <= 1'b0;
            if (fill_evt) breq_q <= 1'b1;
        end
    end

    // Interrupt pass-through with change strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
            chg_q <= 1'b0;
        end else begin
            irq_q <= fdc_irq_i;
            chg_q <= fdc_irq_i ^ irq_q;
        end
    end

    fdma_pingpong #(.BUF_BYTES(BUF_BYTES), .IDX_W(IDX_W)) u_bufs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_byte(req_byte_i),
        .clr_full(clr_full), .pos_clr(pos_clr), .rd_sel(rd_sel), .rd_idx(rd_idx),
        .full(full), .act(act), .fill_evt(fill_evt), .ovf_evt(ovf_evt), .rd_word(rd_word)
    );

    fdma_drain #(.BUF_BYTES(BUF_BYTES), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .WCNT_W(WCNT_W)) u_drain (
        .clk(clk), .rst_n(rst_n), .start(start), .full(full), .act(act),
        .addr_we(addr_we_i), .addr_wdata(addr_wdata_i), .rd_word(rd_word),
        .clr_full(clr_full), .pos_clr(pos_clr), .rd_sel(rd_sel), .rd_idx(rd_idx),
        .mem_we(mem_we_o), .mem_addr(mem_addr_o), .mem_data(mem_data_o),
        .done(burst_done_o), .words(burst_words_o)
    );
endmodule

// File: rtl/fdma_chk.sv
// Property checker for fdma_ctrl, attached by bind.
module fdma_chk #(
    parameter int BUF_BYTES = 16,
    parameter int ADDR_W    = 24,
    parameter int CNT_W     = 16,
    parameter int WCNT_W    = $clog2(BUF_BYTES + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we_i,
    input logic              cnt_we_i,
    input logic [CNT_W-1:0]  cnt_o,
    input logic              addr_we_i,
    input logic              req_i,
    input logic              bus_req_o,
    input logic              bus_gnt_i,
    input logic              mem_we_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic              burst_done_o,
    input logic [WCNT_W-1:0] burst_words_o,
    input logic              err_o,
    input logic [1:0]        ctl_q
);
    assert_req_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_gnt_i) && !req_i |=> !bus_req_o);

    assert_addr_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o && !addr_we_i |=> mem_addr_o == $past(mem_addr_o) + ADDR_W'(2));

    assert_word_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
        burst_done_o |-> (burst_words_o == '0) || (burst_words_o == WCNT_W'(BUF_BYTES / 2))
                         || (burst_words_o == WCNT_W'(BUF_BYTES)));

    assert_cnt_dec_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_i && (cnt_o != '0) && ctl_q[1] && !cnt_we_i |=> cnt_o == $past(cnt_o) - CNT_W'(1));

    assert_cnt_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_we_i && (!req_i || (cnt_o == '0) || !ctl_q[1]) |=> $stable(cnt_o));

    assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        err_o && !cfg_we_i |=> err_o);

    assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        burst_done_o |-> !mem_we_o);
endmodule

bind fdma_ctrl fdma_chk #(
    .BUF_BYTES(BUF_BYTES), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .WCNT_W(WCNT_W)
) u_fdma_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we_i(cfg_we_i), .cnt_we_i(cnt_we_i), .cnt_o(cnt_o),
    .addr_we_i(addr_we_i), .req_i(req_i), .bus_req_o(bus_req_o), .bus_gnt_i(bus_gnt_i),
    .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .burst_done_o(burst_done_o),
    .burst_words_o(burst_words_o), .err_o(err_o), .ctl_q(ctl_q)
);

// File: tb/test_fdma_ctrl.sv
`timescale 1ns/1ps
module test_fdma_ctrl;
    localparam int AW = 24;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we_i = 1'b0;
    logic [1:0]    cfg_wdata_i = 2'b00;
    logic          cnt_we_i = 1'b0;
    logic [CW-1:0] cnt_wdata_i = '0;
    logic [CW-1:0] cnt_o;
    logic          addr_we_i = 1'b0;
    logic [AW-1:0] addr_wdata_i = '0;
    logic          req_i = 1'b0;
    logic [7:0]    req_byte_i = 8'h00;
    logic          fdc_irq_i = 1'b0;
    logic          irq_o, irq_chg_o, bus_req_o, mem_we_o, burst_done_o, err_o;
    logic          bus_gnt_i = 1'b0;
    logic [AW-1:0] mem_addr_o;
    logic [15:0]   mem_data_o;
    logic [4:0]    burst_words_o;

    always #2.5 clk = ~clk;

    fdma_ctrl i_fdma_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_we_i(cfg_we_i), .cfg_wdata_i(cfg_wdata_i),
        .cnt_we_i(cnt_we_i), .cnt_wdata_i(cnt_wdata_i), .cnt_o(cnt_o),
        .addr_we_i(addr_we_i), .addr_wdata_i(addr_wdata_i), .req_i(req_i),
        .req_byte_i(req_byte_i), .fdc_irq_i(fdc_irq_i), .irq_o(irq_o), .irq_chg_o(irq_chg_o),
        .bus_req_o(bus_req_o), .bus_gnt_i(bus_gnt_i), .mem_we_o(mem_we_o),
        .mem_addr_o(mem_addr_o), .mem_data_o(mem_data_o), .burst_done_o(burst_done_o),
        .burst_words_o(burst_words_o), .err_o(err_o)
    );

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    // Bench model of the buffer state, built from the requirements.
    logic [7:0] eb [2][16];
    bit         ef [2];
    int         ea = 0, ep = 0, ecnt = 0, eaddr = 0;
    bit         eerr = 0, ereq = 0, edir = 0, esrc = 0;

    // Captured memory writes.
    logic [AW-1:0] cap_a [32];
    logic [15:0]   cap_d [32];
    int            cap_n = 0;

    always @(negedge clk) begin
        if (mem_we_o && cap_n < 32) begin
            cap_a[cap_n] = mem_addr_o;
            cap_d[cap_n] = mem_data_o;
            cap_n++;
        end
    end

    task automatic chk(string tag, int unsigned act, int unsigned exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] be_word(int b, int w);
        return {eb[b][2*w], eb[b][2*w+1]};
    endfunction

    task automatic set_cfg(bit dir, bit src);
        @(negedge clk);
        cfg_we_i = 1'b1; cfg_wdata_i = {src, dir};
        edir = dir; esrc = src; eerr = 0;
        @(negedge clk);
        cfg_we_i = 1'b0;
    endtask

    task automatic load(int cnt, int addr);
        @(negedge clk);
        cnt_we_i = 1'b1; cnt_wdata_i = CW'(cnt);
        addr_we_i = 1'b1; addr_wdata_i = AW'(addr);
        ecnt = cnt; eaddr = addr;
        @(negedge clk);
        cnt_we_i = 1'b0; addr_we_i = 1'b0;
    endtask

    task automatic push(logic [7:0] b);
        @(negedge clk);
        req_i = 1'b1; req_byte_i = b;
        if (ecnt != 0 && esrc) begin
            ecnt--;
            if (!edir && ep < 16) begin
                eb[ea][ep] = b;
                ep++;
                if (ep == 16) begin
                    ef[ea] = 1;
                    ereq = 1;
                    if (ef[1-ea]) eerr = 1;
                    else begin ea = 1 - ea; ep = 0; end
                end
            end
        end
        @(negedge clk);
        req_i = 1'b0;
    endtask

    task automatic grant(string tag);
        logic [15:0] ew [32];
        logic [AW-1:0] eadr [32];
        int n = 0;
        bit got = 0;
        if (ef[1-ea]) begin
            for (int w = 0; w < 8; w++) begin ew[n] = be_word(1-ea, w); eadr[n] = AW'(eaddr); eaddr += 2; n++; end
            ef[1-ea] = 0;
            if (ef[ea]) begin
                for (int w = 0; w < 8; w++) begin ew[n] = be_word(ea, w); eadr[n] = AW'(eaddr); eaddr += 2; n++; end
                ef[ea] = 0; ep = 0;
            end
        end
        @(negedge clk);
        cap_n = 0;
        bus_gnt_i = 1'b1;
        ereq = 0;
        for (int t = 0; t < 40; t++) begin
            @(negedge clk);
            if (t == 0) chk({tag, " R6 bus_req after grant"}, bus_req_o, 0);
            if (burst_done_o) begin got = 1; break; end
        end
        chk({tag, " R10 done pulse seen"}, got, 1);
        chk({tag, " R8 word count"}, burst_words_o, n);
        chk({tag, " R10 captured writes"}, cap_n, n);
        chk({tag, " R10 strobe low at done"}, mem_we_o, 0);
        bus_gnt_i = 1'b0;
        for (int i = 0; i < n && i < cap_n; i++) begin
            chk({tag, " R7 word data"}, cap_d[i], ew[i]);
            chk({tag, " R9 word address"}, cap_a[i], eadr[i]);
        end
        chk({tag, " R9 final address"}, mem_addr_o, eaddr);
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0d3a));
        for (int b = 0; b < 2; b++) ef[b] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 bus_req", bus_req_o, 0);
        chk("R1 mem_we", mem_we_o, 0);
        chk("R1 err", err_o, 0);
        chk("R1 done", burst_done_o, 0);
        chk("R1 irq", irq_o, 0);
        chk("R1 count", cnt_o, 0);
        chk("R1 address", mem_addr_o, 0);

        // R2: source bit clear, nothing is counted
        load(40, 'h100);
        chk("R9 count readback", cnt_o, 40);
        push(8'hAA);
        chk("R2 source off holds count", cnt_o, 40);

        // R3/R4: one full buffer then an 8-word burst
        set_cfg(0, 1);
        for (int i = 0; i < 15; i++) push(8'($urandom));
        chk("R4 no request before 16th byte", bus_req_o, 0);
        push(8'($urandom));
        chk("R4 request on fill", bus_req_o, 1);
        chk("R2 count decremented", cnt_o, ecnt);
        grant("single");

        // R5/R8: two full buffers, overrun, 16-word burst
        load(100, 'h200);
        for (int i = 0; i < 31; i++) push(8'($urandom));
        chk("R5 no error before second fill", err_o, 0);
        push(8'($urandom));
        chk("R5 error on overrun", err_o, 1);
        push(8'h77);
        chk("R5 error sticky", err_o, 1);
        chk("R2 dropped byte still counted", cnt_o, ecnt);
        grant("double");
        chk("R5 error kept after burst", err_o, 1);
        set_cfg(0, 1);
        chk("R5 error cleared by control write", err_o, 0);

        // R8: grant with nothing full
        grant("empty");

        // R2: counter reaches zero
        load(3, 'h300);
        for (int i = 0; i < 5; i++) push(8'($urandom));
        chk("R2 counter stops at zero", cnt_o, 0);
        load(13, 'h300);
        for (int i = 0; i < 13; i++) push(8'($urandom));
        chk("R4 fill after zero-count stop", bus_req_o, 1);
        grant("count_limit");

        // R3: direction bit set stores nothing
        set_cfg(1, 1);
        load(20, 'h400);
        for (int i = 0; i < 16; i++) push(8'($urandom));
        chk("R3 direction set, count still moves", cnt_o, 4);
        chk("R3 direction set, no request", bus_req_o, 0);
        grant("dir_set");

        // R11: interrupt pass-through
        @(negedge clk); fdc_irq_i = 1'b1;
        @(negedge clk);
        chk("R11 irq follows", irq_o, 1);
        chk("R11 change strobe", irq_chg_o, 1);
        @(negedge clk);
        chk("R11 strobe one cycle", irq_chg_o, 0);
        fdc_irq_i = 1'b0;
        @(negedge clk);
        chk("R11 irq falls", irq_o, 0);
        chk("R11 strobe on fall", irq_chg_o, 1);

        // Random fills of 0..32 bytes in steps of 8, each followed by a grant
        set_cfg(0, 1);
        load(4000, 'h1000);
        for (int r = 0; r < 24; r++) begin
            int nb = 8 * $urandom_range(0, 4);
            for (int i = 0; i < nb; i++) push(8'($urandom));
            chk("R4 random request level", bus_req_o, ereq);
            chk("R5 random error level", err_o, eerr);
            grant("random");
            if (eerr) set_cfg(0, 1);
        end

        finished = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule